// File: doc/BRIEF.md
# System Tick Countdown Timer

This block is a periodic down-counter for generating a regular time base, such as an operating-system tick. Software programs a start value into the reload register and sets the enable bit. The counter then steps down by one on every count tick, wraps back to the reload value after it reaches zero, and raises a sticky wrap flag. If the interrupt-enable bit is set, it also sends a one-cycle pend request to the interrupt controller.

A count tick is either every core clock or a rising edge of an external reference clock. The reference clock is first passed through a synchroniser and an edge detector. For counting on the reference clock to be valid, the core clock must run at least 2.5 times faster than it.

A small register bus gives access to four word registers:

| Offset | Register |
|--------|----------|
| 0x0 | control/status |
| 0x4 | reload |
| 0x8 | current value |
| 0xC | calibration (read-only) |

The counter core is a two-state machine:

- `ST_OFF` holds the count.
- `ST_RUN` counts.
- Transition *arm* (`ST_OFF` to `ST_RUN`, taken when the enable bit is 1) loads the reload value.
- Transition *halt* (`ST_RUN` to `ST_OFF`, taken when the enable bit is 0) freezes the count.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current-value registers all read 0 and `pend_o` is low.
- R2: One clock after a control write sets the enable bit (bit 0), the counter loads the reload value. With the clock-source bit (bit 2) at 1, it then decrements by one per core clock.
- R3: When the count is 0, the next tick reloads it. A reload value N therefore gives a period of N+1 ticks, and this holds up to the maximum reload of 0xFFFFFF.
- R4: When the interrupt-enable bit (bit 1) is 1, `pend_o` is high for exactly the one cycle in which the count has just stepped from 1 to 0. When bit 1 is 0, `pend_o` never goes high.
- R5: The wrap flag reads at bit 16 of control/status. It is set by a 1-to-0 step and cleared by any read of control/status. If a read and a 1-to-0 step fall in the same cycle, the flag stays set.
- R6: With a reload value of 0, the count stays at 0, the wrap flag is never set and `pend_o` is never raised.
- R7: A write of any value to the current-value register sets the count to 0 and clears the wrap flag.
- R8: With bit 2 at 0, the counter ignores the core clock. It decrements once per rising edge of `ref_clk_i`, and each edge takes effect within three core clocks.
- R9: The calibration register reads as {no-reference flag at bit 31, skew flag at bit 30, zeros, 10 ms count at bits 23:0}. Writes to it have no effect. The no-reference flag is 1 exactly when the design has no reference clock, and in that case bit 2 reads as 1 at all times.
- R10: Clearing the enable bit freezes the count at its value one clock after the write.
- R11: Reserved bits read as 0. Only bits 23:0 of the reload register and bits 2:0 of control are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | External reference clock (asynchronous) |
| bus_addr_i | input | 4 | Byte address of the register |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe (clears the wrap flag on a control/status read) |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| pend_o | output | 1 | One-cycle interrupt pend request |

## Verification
All bus operations are driven at falling edges, and read data is taken in the same half cycle.

Timing of each result after its triggering rising edge:

- **Enable write:** the count takes the reload value at the second rising edge after the write, and the first decrement follows at the third.
- **1-to-0 step:** the wrap flag and `pend_o` change at the same edge as the count.
- **Current-value write:** it zeroes the count at the edge that registers the write.
- **Reference clock edge:** it reaches the count after two synchroniser flops and one further edge.

The bench lines up each read with these cycle counts: it inserts a fixed number of idle cycles and derives every expected count as `reload - (k mod (reload+1))`. Reference-clock checks are made only after enough settling cycles that the result no longer depends on the exact phase.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } tick_state_e;

    localparam logic [3:0] OFS_CTRL   = 4'h0;
    localparam logic [3:0] OFS_RELOAD = 4'h4;
    localparam logic [3:0] OFS_CURR   = 4'h8;
    localparam logic [3:0] OFS_CAL    = 4'hC;

    localparam int BIT_EN     = 0;
    localparam int BIT_TICKIE = 1;
    localparam int BIT_CLKSRC = 2;
    localparam int BIT_WRAP   = 16;
    localparam int BIT_SKEW   = 30;
    localparam int BIT_NOREF  = 31;

endpackage

// File: rtl/tick_timer_sync.sv
module tick_timer_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [SYNC_N:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[SYNC_N-1:0], async_i};
        end
    end

    assign rise_o = shreg[SYNC_N-1] & ~shreg[SYNC_N];

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             tickie_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             cur_clr_i,
    input  logic             stat_rd_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_flag_o,
    output logic             pend_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    tick_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic wrap_evt;

    // state transitions: arm (OFF->RUN) and halt (RUN->OFF)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (en_i)  state_d = ST_RUN;
            ST_RUN: if (!en_i) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign wrap_evt = (state_q == ST_RUN) && en_i && tick_i
                      && (cnt_q == CNT_ONE) && !cur_clr_i;

    // counter, flag and pend outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            wrap_flag_o <= 1'b0;
            pend_o      <= 1'b0;
        end else begin
            if (cur_clr_i) begin
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_OFF: if (en_i) cnt_q <= reload_i;
                    ST_RUN: begin
                        if (en_i && tick_i) begin
                            if (cnt_q == '0) cnt_q <= reload_i;
                            else             cnt_q <= cnt_q - CNT_ONE;
                        end
                    end
                    default: cnt_q <= cnt_q;
                endcase
            end

            if (wrap_evt)                    wrap_flag_o <= 1'b1;
            else if (stat_rd_i || cur_clr_i) wrap_flag_o <= 1'b0;

            pend_o <= wrap_evt & tickie_i;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int          CNT_W     = 24,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 4,
    parameter int          SYNC_N    = 2,
    parameter bit          HAS_REF   = 1'b1,
    parameter bit          CAL_SKEW  = 1'b1,
    parameter logic [23:0] CAL_TENMS = 24'd100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_rd_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              pend_o
);
    localparam bit CAL_NOREF = !HAS_REF;

    logic             ctrl_en, ctrl_tickie, ctrl_clksrc;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt;
    logic             wrap_flag;
    logic             ref_rise, tick;
    logic             sel_ctrl, sel_reload, sel_curr, sel_cal;
    logic             cur_wr, ctrl_rd;

    assign sel_ctrl   = (bus_addr_i == ADDR_W'(OFS_CTRL));
    assign sel_reload = (bus_addr_i == ADDR_W'(OFS_RELOAD));
    assign sel_curr   = (bus_addr_i == ADDR_W'(OFS_CURR));
    assign sel_cal    = (bus_addr_i == ADDR_W'(OFS_CAL));

    assign cur_wr  = bus_wr_i & sel_curr;
    assign ctrl_rd = bus_rd_i & sel_ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en     <= 1'b0;
            ctrl_tickie <= 1'b0;
            reload_q    <= '0;
        end else begin
            if (bus_wr_i && sel_ctrl) begin
                ctrl_en     <= bus_wdata_i[BIT_EN];
                ctrl_tickie <= bus_wdata_i[BIT_TICKIE];
            end
            if (bus_wr_i && sel_reload) reload_q <= bus_wdata_i[CNT_W-1:0];
        end
    end

    generate
        if (HAS_REF) begin : g_ref
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      ctrl_clksrc <= 1'b0;
                else if (bus_wr_i && sel_ctrl)   ctrl_clksrc <= bus_wdata_i[BIT_CLKSRC];
            end
            tick_timer_sync #(.SYNC_N(SYNC_N)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .async_i (ref_clk_i),
                .rise_o  (ref_rise)
            );
        end else begin : g_noref
            assign ctrl_clksrc = 1'b1;
            assign ref_rise    = 1'b0;
            wire unused_ref = ref_clk_i;
        end
    endgenerate

    assign tick = ctrl_clksrc ? 1'b1 : ref_rise;

    tick_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctrl_en),
        .tick_i      (tick),
        .tickie_i    (ctrl_tickie),
        .reload_i    (reload_q),
        .cur_clr_i   (cur_wr),
        .stat_rd_i   (ctrl_rd),
        .cnt_o       (cnt),
        .wrap_flag_o (wrap_flag),
        .pend_o      (pend_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (sel_ctrl) begin
            bus_rdata_o[BIT_EN]     = ctrl_en;
            bus_rdata_o[BIT_TICKIE] = ctrl_tickie;
            bus_rdata_o[BIT_CLKSRC] = ctrl_clksrc;
            bus_rdata_o[BIT_WRAP]   = wrap_flag;
        end else if (sel_reload) begin
            bus_rdata_o[CNT_W-1:0] = reload_q;
        end else if (sel_curr) begin
            bus_rdata_o[CNT_W-1:0] = cnt;
        end else if (sel_cal) begin
            bus_rdata_o[CNT_W-1:0] = CAL_TENMS[CNT_W-1:0];
            bus_rdata_o[BIT_SKEW]  = CAL_SKEW;
            bus_rdata_o[BIT_NOREF] = CAL_NOREF;
        end
    end

    wire unused_wdata = ^{bus_wdata_i[DATA_W-1:CNT_W]};

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pend_o,
    input logic             ctrl_tickie,
    input logic             wrap_flag,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload_q,
    input logic             cur_wr
);
    // R2/R3: the count only ever rises by taking the reload value
    a_r3_rise_is_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > $past(cnt)) |-> (cnt == $past(reload_q)));

    // R4: a pend request needs the interrupt enable
    a_r4_pend_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> $past(ctrl_tickie));

    // R4: the pend request lasts a single cycle
    a_r4_pend_single: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |=> !pend_o);

    // R5: the flag is raised only by a 1-to-0 step
    a_r5_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_flag) |-> (cnt == '0 && $past(cnt) == CNT_W'(1)));

    // R7: a current-value write zeroes the count and the flag
    a_r7_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cur_wr) |-> (cnt == '0 && !wrap_flag));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_o      (pend_o),
    .ctrl_tickie (ctrl_tickie),
    .wrap_flag   (wrap_flag),
    .cnt         (cnt),
    .reload_q    (reload_q),
    .cur_wr      (cur_wr)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_clk = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pend;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_timer u_tick_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_clk_i   (ref_clk),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .pend_o      (pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic [23:0] rl, input logic [31:0] ctl);
        bus_write(4'h0, 32'h0);
        bus_write(4'h4, {8'h0, rl});
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, ctl);
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int exp_v;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(4'h0, v); chk("R1 ctrl", v, 32'h0);
        bus_read(4'h4, v); chk("R1 reload", v, 32'h0);
        bus_read(4'h8, v); chk("R1 current", v, 32'h0);
        chk("R1 pend", {31'b0, pend}, 32'h0);

        // R2 R3 R4: sweep of small reload values, core clock, interrupt on
        for (int r = 1; r <= 6; r++) begin
            restart(r[23:0], 32'h7);
            for (int k = 0; k < 2*(r+1)+1; k++) begin
                exp_v = r - (k % (r+1));
                chk("R2 R4 pend", {31'b0, pend}, {31'b0, exp_v == 0});
                bus_read(4'h8, v);
                chk("R2 R3 count", v, exp_v);
            end
            bus_write(4'h0, 32'h0);
            bus_read(4'h0, v); chk("R5 flag set", v, 32'h0001_0000);
            bus_read(4'h0, v); chk("R5 flag read-clear", v, 32'h0);
        end

        // R4: no pend without interrupt enable
        restart(24'd2, 32'h5);
        for (int k = 0; k < 12; k++) begin
            chk("R4 no pend", {31'b0, pend}, 32'h0);
            idle(1);
        end

        // R3: maximum reload
        restart(24'hFFFFFF, 32'h5);
        bus_read(4'h8, v); chk("R3 max load", v, 32'h00FF_FFFF);
        bus_read(4'h8, v); chk("R3 max step", v, 32'h00FF_FFFE);

        // R5: read and wrap in the same cycle
        restart(24'd3, 32'h5);
        idle(2);
        bus_read(4'h0, v); chk("R5 before wrap", v, 32'h5);
        bus_read(4'h0, v); chk("R5 event beats read", v, 32'h0001_0005);
        bus_read(4'h0, v); chk("R5 cleared", v, 32'h5);

        // R6: reload zero
        restart(24'd0, 32'h7);
        for (int k = 0; k < 20; k++) begin
            chk("R6 no pend", {31'b0, pend}, 32'h0);
            idle(1);
        end
        bus_read(4'h8, v); chk("R6 count", v, 32'h0);
        bus_read(4'h0, v); chk("R6 no flag", v, 32'h7);

        // R7: current-value write mid-count
        restart(24'd10, 32'h5);
        idle(12);
        bus_write(4'h8, 32'hDEAD_BEEF);
        bus_read(4'h8, v); chk("R7 zeroed", v, 32'h0);
        bus_read(4'h0, v); chk("R7 flag cleared", v, 32'h5);

        // R10: disable freezes the count
        restart(24'd20, 32'h5);
        bus_read(4'h8, v); chk("R10 start", v, 32'd20);
        idle(3);
        bus_write(4'h0, 32'h4);
        idle(2);
        bus_read(4'h8, v); chk("R10 frozen value", v, 32'd15);
        idle(5);
        bus_read(4'h8, v2); chk("R10 still frozen", v2, 32'd15);

        // R8: reference clock source
        restart(24'd50, 32'h1);
        bus_read(4'h8, v); chk("R8 loaded", v, 32'd50);
        idle(10);
        bus_read(4'h8, v); chk("R8 core clock ignored", v, 32'd50);
        for (int p = 0; p < 7; p++) begin
            ref_clk = 1'b1; idle(3);
            ref_clk = 1'b0; idle(3);
        end
        idle(4);
        bus_read(4'h8, v); chk("R8 ref edges", v, 32'd43);

        // R9: calibration read-only
        bus_read(4'hC, v); chk("R9 cal", v, 32'h4001_86A0);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_read(4'hC, v); chk("R9 cal after write", v, 32'h4001_86A0);

        // R11: reserved bits
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h4, v); chk("R11 reload width", v, 32'h00FF_FFFF);
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'hFFFE_FFF8);
        bus_read(4'h0, v); chk("R11 ctrl reserved", v, 32'h0);
        bus_read(4'h2, v); chk("R11 unmapped", v, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule